// File: doc/BRIEF.md
# I2C Controller Transfer-Length Sequencer

This block sits between software and a bit-level I2C engine on the controller side of a bus. Software writes a control word that carries a start request, a stop request, an 8-bit chunk length, a reload bit, an auto-end bit, a read/write direction and a 7-bit target address. The sequencer turns that word into a series of engine commands: START or repeated START, then the address phase, then one command per data byte, then STOP. It counts down the bytes of the current chunk.

When the count runs out, the mode bits pick the next step. In auto-end mode a STOP follows at once. In software-end mode the transfer-complete flag is raised and SCL is held low until software asks for a STOP or a repeated START. In reload mode the reload-needed flag is raised and SCL is held low until software writes a fresh count. In controller-receive mode the block also decides, byte by byte, whether the engine answers with ACK or NACK.

Engine commands use a valid/ready handshake. Once the sequencer raises `cmd_valid`, it holds `cmd_op` and the attributes that go with it until `cmd_ready` is seen. A command counts as complete in the cycle where both are high, so the engine applies back-pressure simply by keeping `cmd_ready` low until the bus action is finished. No output depends combinationally on any input.

Top module: `i2c_xfer_seq`

## Requirements
- R1: A control write accepts its count field only when no start request is pending. A count written while a start request is pending is dropped, and the next address phase loads the earlier count.
- R2: With auto-end = 1 and reload = 0, the STOP command (cmd_op = 5) is issued right after the programmed number of byte commands (cmd_op = 4). No flag is raised.
- R3: With auto-end = 0 and reload = 0, `flag_tc` and `scl_hold` rise once the count is reached. No further command is issued until a stop or start request arrives. Either request drops the flag.
- R4: With reload = 1, reaching the count raises `flag_tcr` and `scl_hold`, and auto-end has no effect. An accepted count write releases the hold, clears the flag and runs that many more byte commands.
- R5: `start_pend` clears in the cycle after the address command (cmd_op = 3) completes. Pulsing `arb_lost` or `timeout` clears both pending requests and returns the block to idle (`in_ctrl` = 0).
- R6: A start request made from idle waits while `bus_busy` = 1 and then issues START (cmd_op = 1). A start request made while the transfer-complete flag is up issues a repeated START (cmd_op = 2), followed by the address phase.
- R7: A stop request is accepted only while `in_ctrl` = 1. It makes the current byte the last one and is followed by STOP. `stop_pend` clears once the STOP command completes.
- R8: With `ctl_rd` = 1, `cmd_nack` is 1 on the final byte of a non-reload chunk and on a byte sent while a stop request is pending. It is 0 on every other byte and on every non-byte command.
- R9: A control write with start = 0 and stop = 0 leaves both pending requests and any transfer-complete hold unchanged.
- R10: A start request written while `in_ctrl` = 1 and the stored reload bit = 1 is dropped.
- R11: When `enable` = 0 on a clock edge, the next cycle shows the block idle, with both flags, `scl_hold` and both pending requests at 0. Reset gives the same state.
- R12: While `cmd_valid` = 1 and `cmd_ready` = 0, `cmd_valid` stays high and `cmd_op` stays the same on the next cycle, unless an abort or a disable intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Peripheral enable; 0 forces idle and clears state |
| ctl_we | input | 1 | Control-word write strobe |
| ctl_start | input | 1 | Start request (1 sets, 0 no effect) |
| ctl_stop | input | 1 | Stop request (1 sets, 0 no effect) |
| ctl_count | input | 8 | Chunk byte count |
| ctl_reload | input | 1 | Reload mode bit |
| ctl_autoend | input | 1 | Auto-end mode bit |
| ctl_rd | input | 1 | Direction: 1 receive, 0 transmit |
| ctl_addr | input | 7 | Target address |
| bus_busy | input | 1 | Bus is occupied by another controller |
| arb_lost | input | 1 | Arbitration-loss pulse from engine |
| timeout | input | 1 | Timeout-error pulse from engine |
| cmd_valid | output | 1 | Engine command valid |
| cmd_ready | input | 1 | Engine has completed the command |
| cmd_op | output | 3 | 1 START, 2 repeated START, 3 address, 4 byte, 5 STOP |
| cmd_addr | output | 7 | Address for the address phase |
| cmd_rd | output | 1 | Direction for the address and byte phases |
| cmd_nack | output | 1 | Answer this received byte with NACK |
| start_pend | output | 1 | Start request pending |
| stop_pend | output | 1 | Stop request pending |
| in_ctrl | output | 1 | Block currently owns the bus as controller |
| flag_tc | output | 1 | Transfer-complete flag |
| flag_tcr | output | 1 | Reload-needed flag |
| scl_hold | output | 1 | Ask engine to stretch SCL low |

## Verification
The byte sequencing is exercised with three end-of-count modes: auto-end, software-end and reload. The byte counts used differ from mode to mode, so a counter that stops one byte early or late shows up as a wrong number of byte commands before STOP or the flag. Receive transfers are stopped in three ways: by count, by a mid-chunk stop request, and by a repeated START. Comparing the NACK pattern across these separates a last-byte rule from a stop-pending rule. The engine's ready line is driven with a stalling pattern in most runs and is held low in one run, which shows whether commands stay stable under back-pressure. Requests written during the stretched waits and during a pending start separate the repeated-START, reload, ignored-count and ignored-start paths.

// File: rtl/i2c_xfer_seq_pkg.sv
package i2c_xfer_seq_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NONE   = 3'd0,
    OP_START  = 3'd1,
    OP_RSTART = 3'd2,
    OP_ADDR   = 3'd3,
    OP_BYTE   = 3'd4,
    OP_STOP   = 3'd5
  } seq_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_RSTART, ST_ADDR, ST_XFER, ST_TC, ST_TCR, ST_STOP
  } seq_state_e;
endpackage

// File: rtl/xseq_regs.sv
module xseq_regs #(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              wr_en,
  input  logic              wr_start,
  input  logic              wr_stop,
  input  logic [CNT_W-1:0]  wr_count,
  input  logic              wr_reload,
  input  logic              wr_autoend,
  input  logic              wr_rd,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              is_ctrl,
  input  logic              start_clr,
  input  logic              stop_clr,
  output logic [CNT_W-1:0]  cfg_count,
  output logic              cfg_reload,
  output logic              cfg_autoend,
  output logic              cfg_rd,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic              start_pend,
  output logic              stop_pend,
  output logic              count_wr
);
  logic start_set, stop_set;

  // count field is locked while a start request waits
  assign count_wr  = enable & wr_en & ~start_pend;
  assign start_set = wr_en & wr_start & ~(cfg_reload & is_ctrl);
  assign stop_set  = wr_en & wr_stop & is_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_count   <= '0;
      cfg_reload  <= 1'b0;
      cfg_autoend <= 1'b0;
      cfg_rd      <= 1'b0;
      cfg_addr    <= '0;
      start_pend  <= 1'b0;
      stop_pend   <= 1'b0;
    end else if (!enable) begin
      cfg_count   <= '0;
      cfg_reload  <= 1'b0;
      cfg_autoend <= 1'b0;
      cfg_rd      <= 1'b0;
      cfg_addr    <= '0;
      start_pend  <= 1'b0;
      stop_pend   <= 1'b0;
    end else begin
      if (count_wr) cfg_count <= wr_count;
      if (wr_en) begin
        cfg_reload  <= wr_reload;
        cfg_autoend <= wr_autoend;
        cfg_rd      <= wr_rd;
        cfg_addr    <= wr_addr;
      end
      start_pend <= (start_pend & ~start_clr) | start_set;
      stop_pend  <= (stop_pend & ~stop_clr) | stop_set;
    end
  end
endmodule

// File: rtl/xseq_count.sv
module xseq_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero,
  output logic             one
);
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    left <= '0;
    else if (clr)  left <= '0;
    else if (load) left <= load_val;
    else if (dec)  left <= left - CNT_W'(1);
  end

  assign zero = (left == '0);
  assign one  = (left == CNT_W'(1));
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import i2c_xfer_seq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              ctl_we,
  input  logic              ctl_start,
  input  logic              ctl_stop,
  input  logic [CNT_W-1:0]  ctl_count,
  input  logic              ctl_reload,
  input  logic              ctl_autoend,
  input  logic              ctl_rd,
  input  logic [ADDR_W-1:0] ctl_addr,
  input  logic              bus_busy,
  input  logic              arb_lost,
  input  logic              timeout,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [OP_W-1:0]   cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_rd,
  output logic              cmd_nack,
  output logic              start_pend,
  output logic              stop_pend,
  output logic              in_ctrl,
  output logic              flag_tc,
  output logic              flag_tcr,
  output logic              scl_hold
);
  seq_state_e       state, nxt;
  seq_op_e          op;
  logic [CNT_W-1:0] cfg_count, cnt_val;
  logic             cfg_reload, cfg_autoend, cfg_rd;
  logic [ADDR_W-1:0] cfg_addr;
  logic             count_wr, start_clr, stop_clr;
  logic             cnt_load, cnt_dec, cnt_zero, cnt_one;
  logic             fire, abort;

  xseq_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk, .rst_n, .enable,
    .wr_en(ctl_we), .wr_start(ctl_start), .wr_stop(ctl_stop),
    .wr_count(ctl_count), .wr_reload(ctl_reload), .wr_autoend(ctl_autoend),
    .wr_rd(ctl_rd), .wr_addr(ctl_addr), .is_ctrl(in_ctrl),
    .start_clr, .stop_clr,
    .cfg_count, .cfg_reload, .cfg_autoend, .cfg_rd, .cfg_addr,
    .start_pend, .stop_pend, .count_wr
  );

  xseq_count #(.CNT_W(CNT_W)) u_cnt (
    .clk, .rst_n, .clr(~enable), .load(cnt_load), .load_val(cnt_val),
    .dec(cnt_dec), .zero(cnt_zero), .one(cnt_one)
  );

  always_comb begin
    unique case (state)
      ST_START:  op = OP_START;
      ST_RSTART: op = OP_RSTART;
      ST_ADDR:   op = OP_ADDR;
      ST_XFER:   op = cnt_zero ? OP_NONE : OP_BYTE;
      ST_STOP:   op = OP_STOP;
      default:   op = OP_NONE;
    endcase
  end

  assign cmd_valid = (op != OP_NONE);
  assign cmd_op    = op;
  assign cmd_addr  = cfg_addr;
  assign cmd_rd    = cfg_rd;
  assign cmd_nack  = (op == OP_BYTE) & cfg_rd & ((cnt_one & ~cfg_reload) | stop_pend);
  assign fire      = cmd_valid & cmd_ready;
  assign abort     = arb_lost | timeout;
  assign in_ctrl   = (state != ST_IDLE);
  assign flag_tc   = (state == ST_TC);
  assign flag_tcr  = (state == ST_TCR);
  assign scl_hold  = flag_tc | flag_tcr;

  always_comb begin
    nxt       = state;
    cnt_load  = 1'b0;
    cnt_val   = cfg_count;
    cnt_dec   = 1'b0;
    start_clr = 1'b0;
    stop_clr  = 1'b0;
    if (abort) begin
      nxt       = ST_IDLE;
      start_clr = 1'b1;
      stop_clr  = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: if (start_pend && !bus_busy) nxt = ST_START;
        ST_START, ST_RSTART: if (fire) nxt = ST_ADDR;
        ST_ADDR: if (fire) begin
          nxt       = ST_XFER;
          start_clr = 1'b1;
          cnt_load  = 1'b1;
        end
        ST_XFER: begin
          if (cnt_zero) begin
            // end of chunk: stop request, reload, auto-end, restart, wait
            if (stop_pend)        nxt = ST_STOP;
            else if (cfg_reload)  nxt = ST_TCR;
            else if (cfg_autoend) nxt = ST_STOP;
            else if (start_pend)  nxt = ST_RSTART;
            else                  nxt = ST_TC;
          end else if (fire) begin
            cnt_dec = 1'b1;
            if (stop_pend) nxt = ST_STOP;
          end
        end
        ST_TC: begin
          if (stop_pend)       nxt = ST_STOP;
          else if (start_pend) nxt = ST_RSTART;
        end
        ST_TCR: begin
          if (stop_pend) nxt = ST_STOP;
          else if (count_wr) begin
            nxt      = ST_XFER;
            cnt_load = 1'b1;
            cnt_val  = ctl_count;
          end
        end
        ST_STOP: if (fire) begin
          nxt      = ST_IDLE;
          stop_clr = 1'b1;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state <= ST_IDLE;
    else if (!enable) state <= ST_IDLE;
    else              state <= nxt;
  end
endmodule

// File: rtl/i2c_xfer_seq_chk.sv
module i2c_xfer_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       ctl_we,
  input logic       arb_lost,
  input logic       timeout,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [2:0] cmd_op,
  input logic       cmd_rd,
  input logic       cmd_nack,
  input logic       start_pend,
  input logic       stop_pend,
  input logic       in_ctrl,
  input logic       flag_tc,
  input logic       flag_tcr,
  input logic       scl_hold
);
  // R12
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !arb_lost && !timeout && cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op)));
  // R3
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_tc || flag_tcr) |-> !cmd_valid);
  // R11
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!in_ctrl && !start_pend && !stop_pend && !scl_hold));
  // R5
  addr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !ctl_we && cmd_valid && cmd_ready && cmd_op == 3'd3) |=> !start_pend);
  // R8
  nack_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_nack) |-> (cmd_op == 3'd4 && cmd_rd));
  // R7
  stop_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !ctl_we && cmd_valid && cmd_ready && cmd_op == 3'd5) |=> (!stop_pend && !in_ctrl));
endmodule

bind i2c_xfer_seq i2c_xfer_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .ctl_we(ctl_we),
  .arb_lost(arb_lost), .timeout(timeout), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_rd(cmd_rd), .cmd_nack(cmd_nack),
  .start_pend(start_pend), .stop_pend(stop_pend), .in_ctrl(in_ctrl),
  .flag_tc(flag_tc), .flag_tcr(flag_tcr), .scl_hold(scl_hold)
);

// File: tb/i2c_xfer_seq_test.sv
`timescale 1ns/1ps
module i2c_xfer_seq_test;
  logic clk = 0, rst_n = 0, enable = 0;
  logic ctl_we = 0, ctl_start = 0, ctl_stop = 0, ctl_reload = 0, ctl_autoend = 0, ctl_rd = 0;
  logic [7:0] ctl_count = 0;
  logic [6:0] ctl_addr = 7'h2a;
  logic bus_busy = 0, arb_lost = 0, timeout = 0, cmd_ready = 0;
  logic cmd_valid, cmd_rd, cmd_nack, start_pend, stop_pend, in_ctrl, flag_tc, flag_tcr, scl_hold;
  logic [2:0] cmd_op;
  logic [6:0] cmd_addr;

  i2c_xfer_seq uut (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int rdy_mode = 1;
  logic [7:0] lfsr = 8'h5b;
  int n_start = 0, n_rstart = 0, n_addr = 0, n_byte = 0, n_stop = 0;
  logic [15:0] nack_hist = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  // engine ready pattern
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    cmd_ready <= (rdy_mode == 1) ? 1'b1 : (rdy_mode == 2) ? lfsr[0] : 1'b0;
  end

  // command monitor
  always @(posedge clk) if (cmd_valid && cmd_ready) begin
    case (cmd_op)
      3'd1: n_start++;
      3'd2: n_rstart++;
      3'd3: n_addr++;
      3'd4: begin n_byte++; nack_hist <= {nack_hist[14:0], cmd_nack}; end
      3'd5: n_stop++;
      default: ;
    endcase
  end

  // behavioural reference, phases: 0 idle 1 start 2 restart 3 addr 4 data 5 wait-sw 6 wait-reload 7 stop
  int m_ph = 0, m_left = 0, m_cnt = 0;
  bit m_rel = 0, m_ae = 0, m_rd = 0, m_sp = 0, m_pp = 0;

  function automatic int m_op();
    case (m_ph)
      1: return 1;
      2: return 2;
      3: return 3;
      4: return (m_left != 0) ? 4 : 0;
      7: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic bit m_nack();
    return (m_op() == 4) && m_rd && ((m_left == 1 && !m_rel) || m_pp);
  endfunction

  always @(posedge clk) begin
    if (!rst_n || !enable) begin
      m_ph = 0; m_left = 0; m_cnt = 0; m_rel = 0; m_ae = 0; m_rd = 0; m_sp = 0; m_pp = 0;
    end else begin
      automatic bit f = (m_op() != 0) && cmd_ready;
      automatic bit ctrl = (m_ph != 0);
      automatic bit cw = ctl_we && !m_sp;
      automatic int np = m_ph, nl = m_left;
      automatic bit sc = 0, pc = 0, nsp, npp;
      if (arb_lost || timeout) begin np = 0; sc = 1; pc = 1; end
      else case (m_ph)
        0: if (m_sp && !bus_busy) np = 1;
        1, 2: if (f) np = 3;
        3: if (f) begin np = 4; sc = 1; nl = m_cnt; end
        4: if (m_left == 0) begin
             if (m_pp) np = 7; else if (m_rel) np = 6; else if (m_ae) np = 7;
             else if (m_sp) np = 2; else np = 5;
           end else if (f) begin nl = m_left - 1; if (m_pp) np = 7; end
        5: if (m_pp) np = 7; else if (m_sp) np = 2;
        6: if (m_pp) np = 7; else if (cw) begin np = 4; nl = ctl_count; end
        7: if (f) begin np = 0; pc = 1; end
        default: np = 0;
      endcase
      nsp = (m_sp && !sc) || (ctl_we && ctl_start && !(m_rel && ctrl));
      npp = (m_pp && !pc) || (ctl_we && ctl_stop && ctrl);
      if (ctl_we) begin
        if (cw) m_cnt = ctl_count;
        m_rel = ctl_reload; m_ae = ctl_autoend; m_rd = ctl_rd;
      end
      m_sp = nsp; m_pp = npp; m_ph = np; m_left = nl;
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) if (rst_n) begin
    chk(cmd_valid == (m_op() != 0) && (!cmd_valid || cmd_op == 3'(m_op())), "R12 cmd", int'(cmd_op), m_op());
    chk(cmd_nack == m_nack(), "R8 nack", cmd_nack, m_nack());
    chk(flag_tc == (m_ph == 5), "R3 tc", flag_tc, m_ph == 5);
    chk(flag_tcr == (m_ph == 6), "R4 tcr", flag_tcr, m_ph == 6);
    chk(scl_hold == (m_ph == 5 || m_ph == 6), "R3 hold", scl_hold, m_ph == 5 || m_ph == 6);
    chk(start_pend == m_sp, "R5 start_pend", start_pend, m_sp);
    chk(stop_pend == m_pp, "R7 stop_pend", stop_pend, m_pp);
    chk(in_ctrl == (m_ph != 0), "R11 in_ctrl", in_ctrl, m_ph != 0);
  end

  task automatic wr(input bit st, input bit sp, input int cnt, input bit rel, input bit ae, input bit rd);
    @(negedge clk);
    ctl_we = 1; ctl_start = st; ctl_stop = sp; ctl_count = 8'(cnt);
    ctl_reload = rel; ctl_autoend = ae; ctl_rd = rd;
    @(negedge clk);
    ctl_we = 0; ctl_start = 0; ctl_stop = 0;
  endtask

  // 0: idle and nothing pending, 1: tc, 2: tcr
  task automatic wait_for(input int what);
    for (int g = 0; g < 3000; g++) begin
      @(negedge clk);
      if (what == 0 && !in_ctrl && !start_pend) return;
      if (what == 1 && flag_tc) return;
      if (what == 2 && flag_tcr) return;
    end
  endtask

  task automatic clr_counts();
    n_start = 0; n_rstart = 0; n_addr = 0; n_byte = 0; n_stop = 0; nack_hist = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; enable = 1;
    @(negedge clk);
    // R11 reset state
    chk(!in_ctrl && !cmd_valid && !scl_hold && !start_pend, "R11 reset", in_ctrl, 0);

    // R2 auto-end write of 3 bytes
    rdy_mode = 2; clr_counts();
    wr(1, 0, 3, 0, 1, 0);
    wait_for(0);
    chk(n_byte == 3, "R2 bytes", n_byte, 3);
    chk(n_stop == 1 && n_start == 1 && n_addr == 1, "R2 stop", n_stop, 1);

    // R6 start waits for a free bus
    clr_counts(); bus_busy = 1;
    wr(1, 0, 2, 0, 1, 0);
    repeat (20) @(negedge clk);
    chk(!in_ctrl && start_pend && n_start == 0, "R6 busy wait", n_start, 0);
    bus_busy = 0;
    wait_for(0);
    chk(n_start == 1 && n_byte == 2, "R6 start after free", n_start, 1);

    // R3 / R8 software end, receive 4
    clr_counts();
    wr(1, 0, 4, 0, 0, 1);
    wait_for(1);
    chk(n_byte == 4 && scl_hold, "R3 tc after 4", n_byte, 4);
    chk(nack_hist[3:0] == 4'b0001, "R8 last nack", int'(nack_hist[3:0]), 1);
    repeat (10) @(negedge clk);
    chk(n_byte == 4 && flag_tc && !cmd_valid, "R3 held", n_byte, 4);

    // R9 write with no requests leaves hold in place
    wr(0, 0, 2, 0, 0, 1);
    repeat (5) @(negedge clk);
    chk(flag_tc && scl_hold && !start_pend && !stop_pend, "R9 no effect", flag_tc, 1);

    // R6 repeated start from tc, 2 bytes
    clr_counts();
    wr(1, 0, 2, 0, 0, 1);
    wait_for(1);
    chk(n_rstart == 1 && n_start == 0, "R6 rstart", n_rstart, 1);
    chk(n_byte == 2 && nack_hist[1:0] == 2'b01, "R8 rstart bytes", n_byte, 2);

    // R1 count write while start pending is dropped
    clr_counts(); rdy_mode = 1;
    wr(1, 0, 3, 0, 0, 0);
    wr(0, 0, 7, 0, 0, 0);
    rdy_mode = 2;
    wait_for(1);
    chk(n_byte == 3, "R1 count kept", n_byte, 3);

    // R7 stop from tc
    clr_counts();
    wr(0, 1, 3, 0, 0, 0);
    wait_for(0);
    chk(n_stop == 1 && !stop_pend && n_byte == 0, "R7 stop from tc", n_stop, 1);

    // R7 stop request is ignored while idle
    wr(0, 1, 3, 0, 0, 0);
    @(negedge clk);
    chk(!stop_pend, "R7 idle stop dropped", stop_pend, 0);

    // R7 / R8 stop in the middle of a receive chunk
    clr_counts();
    wr(1, 0, 10, 0, 0, 1);
    for (int g = 0; g < 2000 && n_byte < 2; g++) @(negedge clk);
    wr(0, 1, 10, 0, 0, 1);
    wait_for(0);
    chk(n_byte < 10 && n_stop == 1, "R7 early stop", n_byte, 10);
    chk(nack_hist[0] == 1'b1 && nack_hist[1] == 1'b0, "R8 stop nack", int'(nack_hist[1:0]), 1);

    // R4 / R10 reload chunks 2 + 5 + 1
    clr_counts();
    wr(1, 0, 2, 1, 1, 1);
    wait_for(2);
    chk(n_byte == 2 && n_stop == 0 && scl_hold, "R4 tcr autoend ignored", n_stop, 0);
    chk(nack_hist[1:0] == 2'b00, "R8 reload no nack", int'(nack_hist[1:0]), 0);
    wr(1, 0, 5, 1, 1, 1);
    chk(!start_pend, "R10 start dropped", start_pend, 0);
    wait_for(2);
    chk(n_byte == 7 && n_rstart == 0, "R4 second chunk", n_byte, 7);
    wr(0, 0, 1, 0, 1, 1);
    wait_for(0);
    chk(n_byte == 8 && n_stop == 1 && nack_hist[0], "R4 final chunk", n_byte, 8);

    // R5 / R12 stalled start, then arbitration loss
    clr_counts(); rdy_mode = 0;
    wr(1, 0, 3, 0, 1, 0);
    repeat (3) @(negedge clk);
    chk(cmd_valid && cmd_op == 3'd1, "R12 stall op", int'(cmd_op), 1);
    repeat (4) @(negedge clk);
    chk(cmd_valid && cmd_op == 3'd1, "R12 still held", int'(cmd_op), 1);
    arb_lost = 1; @(negedge clk); arb_lost = 0;
    chk(!start_pend && !in_ctrl, "R5 arb clear", start_pend, 0);

    // R5 timeout during data
    rdy_mode = 2;
    wr(1, 0, 9, 0, 0, 0);
    for (int g = 0; g < 2000 && !(cmd_valid && cmd_op == 3'd4); g++) @(negedge clk);
    timeout = 1; @(negedge clk); timeout = 0;
    chk(!in_ctrl && !start_pend && !cmd_valid, "R5 timeout idle", in_ctrl, 0);

    // R5 start_pend clears after address
    clr_counts(); rdy_mode = 1;
    wr(1, 0, 2, 0, 0, 0);
    for (int g = 0; g < 100 && n_addr == 0; g++) @(negedge clk);
    chk(!start_pend, "R5 addr clear", start_pend, 0);
    wait_for(1);

    // R11 disable releases hold
    chk(scl_hold, "R11 pre hold", scl_hold, 1);
    enable = 0; @(negedge clk);
    chk(!in_ctrl && !scl_hold && !flag_tc && !flag_tcr && !start_pend && !stop_pend,
        "R11 disable", scl_hold, 0);
    enable = 1;
    repeat (5) @(negedge clk);
    chk(!in_ctrl && !cmd_valid, "R11 stays idle", in_ctrl, 0);

    finish_run();
  end
endmodule